// File: doc/BRIEF.md
# DSP Serial Link Port

This block attaches one signal processor to a shared switch fabric through a four-wire framed serial link. It generates the bit clocks for both directions and deserializes incoming 32-bit words. The first word of every block is a header naming the sender, the destination, the number of data words and the block's position within the message. The port presents that header to an external allocator as a request and holds it until a decision arrives.

The port then sends a reply word back over the serial transmit line. The reply reports whether the whole block was accepted, only part of it, or none of it. After an accepted or partly accepted reply, the port writes exactly the granted number of following data words into the FIFO the allocator chose, each tagged with the destination address. Any words of the block beyond the grant are swallowed. After a refusal the port goes back to waiting for a new header.

Top module: `dsp_link_port`

## Requirements
- R1: Both bit clock outputs run at the system clock frequency divided by CLK_DIV (default 4). Received data is sampled at the falling edge of the bit clock, and transmitted data changes at that same edge.
- R2: A receive frame sync sampled high in one bit slot marks the next 32 bit slots as one word, most significant bit first. The frame sync is ignored while a word is being received.
- R3: In a header word, bits [31:28] are the source, [27:24] the target, [23:16] the word count and [15:12] the block index. Bits [11:0] are ignored. The first three fields and the index appear on req_src, req_tgt, req_count and req_index.
- R4: req_valid rises after a header is received. It stays high with unchanged fields until rsp_valid is sampled high. rsp_valid has no effect at any other time.
- R5: Each decision produces one reply word on the transmit line. tx_fs is high for the single bit slot before the MSB. The reply has source [31:28], target [27:24], granted count [23:16], index [15:12], zeros in [11:2] and status in [1:0].
- R6: The status is WAIT (2'b10) with a grant of 0 when rsp_full is high or rsp_count is 0. It is LIMITED (2'b11) with a grant of rsp_count when rsp_count is below the requested count. Otherwise it is OK (2'b01) with a grant equal to the requested count.
- R7: After OK or LIMITED, the next granted-count received words are each written once on fifo_wr. fifo_data carries the unchanged word, fifo_sel equals the rsp_fifo value sampled with the decision, and fifo_tag equals the target.
- R8: After LIMITED, the following (requested minus granted) received words are discarded. The word after them is decoded as a new header. After OK, the word following the last granted word is decoded as a new header and is not written.
- R9: After WAIT, no word is written and the next received word is decoded as a header.
- R10: While reset is asserted and right after it, req_valid, fifo_wr, tx_fs and tx_d are low.
- R11: Words received while a decision is pending are discarded. They are neither written nor decoded as headers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bclk | output | 1 | Receive bit clock to the processor |
| rx_fs | input | 1 | Receive frame sync |
| rx_d | input | 1 | Receive serial data |
| tx_bclk | output | 1 | Transmit bit clock to the processor |
| tx_fs | output | 1 | Transmit frame sync |
| tx_d | output | 1 | Transmit serial data |
| req_valid | output | 1 | Allocation request pending |
| req_src | output | 4 | Source address of the pending header |
| req_tgt | output | 4 | Target address of the pending header |
| req_count | output | 8 | Requested word count |
| req_index | output | 4 | Block index of the pending header |
| rsp_valid | input | 1 | Allocator decision strobe |
| rsp_full | input | 1 | Allocator found no space |
| rsp_count | input | 8 | Words the allocator can take |
| rsp_fifo | input | 2 | FIFO chosen by the allocator |
| fifo_wr | output | 1 | Write strobe into the chosen FIFO |
| fifo_sel | output | 2 | FIFO selected for the write |
| fifo_tag | output | 4 | Target address tag of the written word |
| fifo_data | output | 32 | Forwarded data word |

## Verification
The decision path is tried with an allocator answer that exceeds the request, one that is smaller, one that is exactly equal, one that reports no space, and one that offers zero words. Together these separate the three status codes and the grant-clamping rule. Each accepted block is followed by its full requested payload, so a LIMITED case shows whether the surplus is dropped or leaks into the FIFO. The word after each block is checked as a header, which shows whether the forward and drop counters end on the right word. Directed cases send a word while a decision is pending and a surplus word after an OK block, and they measure the bit clock period. A header with a nonzero reserved field shows that those bits do not reach the reply.

// File: rtl/dsp_link_pkg.sv
`timescale 1ns/1ps
package dsp_link_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 4;
  localparam int CNT_W  = 8;
  localparam int IDX_W  = 4;
  localparam int SEL_W  = 2;
  localparam int HDR_W  = 2 * ADDR_W + CNT_W + IDX_W;
  localparam int PAD_W  = WORD_W - HDR_W - 2;

  typedef enum logic [1:0] {
    RS_OK      = 2'b01,
    RS_WAIT    = 2'b10,
    RS_LIMITED = 2'b11
  } reply_status_e;

  typedef struct packed {
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] tgt;
    logic [CNT_W-1:0]  count;
    logic [IDX_W-1:0]  index;
  } hdr_t;

  typedef enum logic [1:0] {
    LS_IDLE = 2'b00,
    LS_REQ  = 2'b01,
    LS_FWD  = 2'b10
  } link_state_e;
endpackage

// File: rtl/dsp_link_bitclk.sv
`timescale 1ns/1ps
module dsp_link_bitclk #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic strobe,
  output logic bclk
);
  localparam int CW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int HALF = CLK_DIV / 2;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == CW'(CLK_DIV - 1)) cnt_d = '0;
    else                           cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign strobe = (cnt_q == CW'(CLK_DIV - 1));
  assign bclk   = (cnt_q >= CW'(HALF));
endmodule

// File: rtl/dsp_link_rx.sv
`timescale 1ns/1ps
module dsp_link_rx
  import dsp_link_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              fs,
  input  logic              d,
  output logic              word_vld,
  output logic [WORD_W-1:0] word
);
  localparam int BW = $clog2(WORD_W);

  logic              busy_q, busy_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              vld_q, vld_d;

  always_comb begin
    busy_d = busy_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    vld_d  = 1'b0;
    if (strobe) begin
      if (busy_q) begin
        sh_d  = {sh_q[WORD_W-2:0], d};
        bit_d = bit_q + BW'(1);
        if (bit_q == BW'(WORD_W - 1)) begin
          busy_d = 1'b0;
          vld_d  = 1'b1;
        end
      end else if (fs) begin
        busy_d = 1'b1;
        bit_d  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      bit_q  <= '0;
      sh_q   <= '0;
      vld_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      bit_q  <= bit_d;
      vld_q  <= vld_d;
      if (strobe) sh_q <= sh_d;
    end
  end

  assign word_vld = vld_q;
  assign word     = sh_q;

  p_word_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);
endmodule

// File: rtl/dsp_link_tx.sv
`timescale 1ns/1ps
module dsp_link_tx
  import dsp_link_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  output logic              fs,
  output logic              d
);
  localparam int BW = $clog2(WORD_W) + 1;

  logic              pend_q, pend_d;
  logic              shift_q, shift_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              fs_q, fs_d;
  logic              d_q, d_d;

  always_comb begin
    pend_d  = pend_q;
    shift_d = shift_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    fs_d    = fs_q;
    d_d     = d_q;
    if (start && !pend_q && !shift_q) begin
      pend_d = 1'b1;
      sh_d   = word;
    end
    if (strobe) begin
      if (pend_q) begin
        pend_d  = 1'b0;
        shift_d = 1'b1;
        bit_d   = '0;
        fs_d    = 1'b1;
        d_d     = 1'b0;
      end else if (shift_q) begin
        fs_d = 1'b0;
        if (bit_q == BW'(WORD_W)) begin
          d_d     = 1'b0;
          shift_d = 1'b0;
        end else begin
          d_d   = sh_q[WORD_W-1];
          sh_d  = {sh_q[WORD_W-2:0], 1'b0};
          bit_d = bit_q + BW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      shift_q <= 1'b0;
      bit_q   <= '0;
      sh_q    <= '0;
      fs_q    <= 1'b0;
      d_q     <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      shift_q <= shift_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      fs_q    <= fs_d;
      d_q     <= d_d;
    end
  end

  assign fs = fs_q;
  assign d  = d_q;

  p_fs_one_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_q && strobe) |=> !fs_q);
endmodule

// File: rtl/dsp_link_port.sv
`timescale 1ns/1ps
module dsp_link_port
  import dsp_link_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              rx_bclk,
  input  logic              rx_fs,
  input  logic              rx_d,
  output logic              tx_bclk,
  output logic              tx_fs,
  output logic              tx_d,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_src,
  output logic [ADDR_W-1:0] req_tgt,
  output logic [CNT_W-1:0]  req_count,
  output logic [IDX_W-1:0]  req_index,
  input  logic              rsp_valid,
  input  logic              rsp_full,
  input  logic [CNT_W-1:0]  rsp_count,
  input  logic [SEL_W-1:0]  rsp_fifo,
  output logic              fifo_wr,
  output logic [SEL_W-1:0]  fifo_sel,
  output logic [ADDR_W-1:0] fifo_tag,
  output logic [WORD_W-1:0] fifo_data
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  logic              strobe, bclk;
  logic              rx_vld;
  logic [WORD_W-1:0] rx_word;
  logic              tx_start_q, tx_start_d;
  logic [WORD_W-1:0] tx_word_q, tx_word_d;

  dsp_link_bitclk #(.CLK_DIV(CLK_DIV)) u_bitclk (
    .clk(clk), .rst_n(srst_n), .strobe(strobe), .bclk(bclk));

  dsp_link_rx u_rx (
    .clk(clk), .rst_n(srst_n), .strobe(strobe), .fs(rx_fs), .d(rx_d),
    .word_vld(rx_vld), .word(rx_word));

  dsp_link_tx u_tx (
    .clk(clk), .rst_n(srst_n), .strobe(strobe), .start(tx_start_q),
    .word(tx_word_q), .fs(tx_fs), .d(tx_d));

  assign rx_bclk = bclk;
  assign tx_bclk = bclk;

  link_state_e       state_q, state_d;
  hdr_t              hdr_q;
  logic              hdr_ld;
  logic [SEL_W-1:0]  sel_q;
  logic              cnt_ld, fwd_dec, drop_dec;
  logic [CNT_W-1:0]  fwd_left_q, drop_left_q;
  logic              wr_q, wr_d;
  logic [WORD_W-1:0] data_q;
  reply_status_e     status;
  logic [CNT_W-1:0]  grant;
  logic              last_word;

  // allocator decision to reply status and granted count
  always_comb begin
    if (rsp_full || rsp_count == '0) begin
      status = RS_WAIT;
      grant  = '0;
    end else if (rsp_count < hdr_q.count) begin
      status = RS_LIMITED;
      grant  = rsp_count;
    end else begin
      status = RS_OK;
      grant  = hdr_q.count;
    end
  end

  assign tx_word_d = {hdr_q.src, hdr_q.tgt, grant, hdr_q.index, {PAD_W{1'b0}}, status};
  assign last_word = (fwd_left_q == CNT_W'(1) && drop_left_q == '0) ||
                     (fwd_left_q == '0 && drop_left_q == CNT_W'(1));

  always_comb begin
    state_d    = state_q;
    hdr_ld     = 1'b0;
    cnt_ld     = 1'b0;
    fwd_dec    = 1'b0;
    drop_dec   = 1'b0;
    wr_d       = 1'b0;
    tx_start_d = 1'b0;
    unique case (state_q)
      LS_IDLE: if (rx_vld) begin
        hdr_ld  = 1'b1;
        state_d = LS_REQ;
      end
      LS_REQ: if (rsp_valid) begin
        tx_start_d = 1'b1;
        if (status == RS_WAIT || grant == '0) begin
          state_d = LS_IDLE;
        end else begin
          cnt_ld  = 1'b1;
          state_d = LS_FWD;
        end
      end
      LS_FWD: if (rx_vld) begin
        if (fwd_left_q != '0) begin
          wr_d    = 1'b1;
          fwd_dec = 1'b1;
        end else begin
          drop_dec = 1'b1;
        end
        if (last_word) state_d = LS_IDLE;
      end
      default: state_d = LS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q     <= LS_IDLE;
      hdr_q       <= '0;
      sel_q       <= '0;
      fwd_left_q  <= '0;
      drop_left_q <= '0;
      wr_q        <= 1'b0;
      data_q      <= '0;
      tx_start_q  <= 1'b0;
      tx_word_q   <= '0;
    end else begin
      state_q    <= state_d;
      wr_q       <= wr_d;
      tx_start_q <= tx_start_d;
      if (hdr_ld)     hdr_q     <= rx_word[WORD_W-1 -: HDR_W];
      if (tx_start_d) tx_word_q <= tx_word_d;
      if (wr_d)       data_q    <= rx_word;
      if (cnt_ld) begin
        sel_q       <= rsp_fifo;
        fwd_left_q  <= grant;
        drop_left_q <= hdr_q.count - grant;
      end else begin
        if (fwd_dec)  fwd_left_q  <= fwd_left_q - CNT_W'(1);
        if (drop_dec) drop_left_q <= drop_left_q - CNT_W'(1);
      end
    end
  end

  assign req_valid = (state_q == LS_REQ);
  assign req_src   = hdr_q.src;
  assign req_tgt   = hdr_q.tgt;
  assign req_count = hdr_q.count;
  assign req_index = hdr_q.index;
  assign fifo_wr   = wr_q;
  assign fifo_sel  = sel_q;
  assign fifo_tag  = hdr_q.tgt;
  assign fifo_data = data_q;

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (req_valid && !rsp_valid) |=> (req_valid &&
      $stable({req_src, req_tgt, req_count, req_index})));

  p_idle_no_write_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (state_q == LS_IDLE && $past(state_q == LS_IDLE)) |-> !wr_q);

  p_reply_once_r5: assert property (@(posedge clk) disable iff (!srst_n)
    tx_start_q |=> !tx_start_q);

  p_write_in_budget_r7: assert property (@(posedge clk) disable iff (!srst_n)
    wr_d |-> (fwd_left_q != '0));
endmodule

// File: tb/dsp_link_port_tb.sv
`timescale 1ns/1ps
module dsp_link_port_tb;
  localparam int DIV = 4;

  logic clk, rst_n;
  logic rx_bclk, rx_fs, rx_d, tx_bclk, tx_fs, tx_d;
  logic req_valid;
  logic [3:0] req_src, req_tgt, req_index;
  logic [7:0] req_count;
  logic rsp_valid, rsp_full;
  logic [7:0] rsp_count;
  logic [1:0] rsp_fifo;
  logic fifo_wr;
  logic [1:0] fifo_sel;
  logic [3:0] fifo_tag;
  logic [31:0] fifo_data;

  dsp_link_port #(.CLK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_bclk(rx_bclk), .rx_fs(rx_fs), .rx_d(rx_d),
    .tx_bclk(tx_bclk), .tx_fs(tx_fs), .tx_d(tx_d), .req_valid(req_valid),
    .req_src(req_src), .req_tgt(req_tgt), .req_count(req_count),
    .req_index(req_index), .rsp_valid(rsp_valid), .rsp_full(rsp_full),
    .rsp_count(rsp_count), .rsp_fifo(rsp_fifo), .fifo_wr(fifo_wr),
    .fifo_sel(fifo_sel), .fifo_tag(fifo_tag), .fifo_data(fifo_data));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int tests = 0, fails = 0;
  bit finished = 0;

  logic [31:0] log_data [64];
  logic [1:0]  log_sel  [64];
  logic [3:0]  log_tag  [64];
  int wr_n = 0;

  always @(negedge clk) if (rst_n && fifo_wr && wr_n < 64) begin
    log_data[wr_n] = fifo_data;
    log_sel[wr_n]  = fifo_sel;
    log_tag[wr_n]  = fifo_tag;
    wr_n++;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [31:0] w);
    @(posedge rx_bclk); rx_fs = 1'b1; rx_d = 1'b0;
    for (int i = 31; i >= 0; i--) begin
      @(posedge rx_bclk); rx_fs = 1'b0; rx_d = w[i];
    end
    @(posedge rx_bclk); rx_d = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_req(output bit seen);
    seen = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (req_valid) begin seen = 1; break; end
    end
  endtask

  task automatic decide(input logic full, input logic [7:0] cnt, input logic [1:0] f);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_full = full; rsp_count = cnt; rsp_fifo = f;
    @(negedge clk);
    rsp_valid = 1'b0; rsp_full = 1'b0; rsp_count = 8'd0; rsp_fifo = 2'd0;
  endtask

  task automatic get_reply(output logic [31:0] w, output bit seen);
    seen = 0; w = '0;
    for (int i = 0; i < 200; i++) begin
      @(posedge tx_bclk);
      if (tx_fs) begin seen = 1; break; end
    end
    if (seen) for (int i = 0; i < 32; i++) begin
      @(posedge tx_bclk); w = {w[30:0], tx_d};
    end
  endtask

  function automatic logic [31:0] dword(input int k, input int i);
    return 32'hC0DE0000 | (32'(k) << 8) | 32'(i);
  endfunction

  typedef struct packed {
    logic [31:0] ctrl;
    logic        full;
    logic [7:0]  rcnt;
    logic [1:0]  fifo;
    logic [1:0]  st;
    logic [7:0]  grant;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{32'h1203_0000, 1'b0, 8'd10, 2'd0, 2'b01, 8'd3},
    '{32'h3506_2000, 1'b0, 8'd4,  2'd2, 2'b11, 8'd4},
    '{32'h4905_1000, 1'b1, 8'd7,  2'd1, 2'b10, 8'd0},
    '{32'h2002_FABC, 1'b0, 8'd2,  2'd3, 2'b01, 8'd2},
    '{32'hFF08_7000, 1'b0, 8'd0,  2'd1, 2'b10, 8'd0},
    '{32'h6701_3000, 1'b0, 8'd1,  2'd1, 2'b01, 8'd1},
    '{32'h8A04_5000, 1'b0, 8'd1,  2'd0, 2'b11, 8'd1}
  };

  initial begin
    #(8 * 200000);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit seen;
    logic [31:0] rep, expw;
    int base;
    time t0, t1;
    rst_n = 1'b0; rx_fs = 1'b0; rx_d = 1'b0;
    rsp_valid = 1'b0; rsp_full = 1'b0; rsp_count = 8'd0; rsp_fifo = 2'd0;
    repeat (3) @(negedge clk);
    check(!req_valid && !fifo_wr && !tx_fs && !tx_d, "R10 reset outputs",
          {28'd0, req_valid, fifo_wr, tx_fs, tx_d}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!req_valid && !fifo_wr && !tx_fs && !tx_d, "R10 after release",
          {28'd0, req_valid, fifo_wr, tx_fs, tx_d}, 32'd0);

    // R1: bit clock period
    @(posedge rx_bclk); t0 = $time;
    @(posedge rx_bclk); t1 = $time;
    check((t1 - t0) == 8 * DIV, "R1 rx bit clock period", 32'(t1 - t0), 32'(8 * DIV));
    @(posedge tx_bclk); t0 = $time;
    @(posedge tx_bclk); t1 = $time;
    check((t1 - t0) == 8 * DIV, "R1 tx bit clock period", 32'(t1 - t0), 32'(8 * DIV));

    // table walk: header decode, decision, reply, forwarding and drop
    for (int k = 0; k < NV; k++) begin
      base = wr_n;
      send_word(VEC[k].ctrl);
      wait_req(seen);
      check(seen, "R2 R3 header starts request", {31'd0, seen}, 32'd1);
      check({req_src, req_tgt, req_count, req_index} == VEC[k].ctrl[31:12],
            "R3 header fields", {12'd0, req_src, req_tgt, req_count, req_index},
            {12'd0, VEC[k].ctrl[31:12]});
      repeat (5) @(negedge clk);
      check(req_valid, "R4 request held", {31'd0, req_valid}, 32'd1);
      decide(VEC[k].full, VEC[k].rcnt, VEC[k].fifo);
      get_reply(rep, seen);
      expw = {VEC[k].ctrl[31:24], VEC[k].grant, VEC[k].ctrl[15:12], 10'd0, VEC[k].st};
      check(seen && rep == expw, "R5 R6 reply word", rep, expw);
      if (VEC[k].st != 2'b10)
        for (int i = 0; i < int'(VEC[k].ctrl[23:16]); i++) send_word(dword(k, i));
      repeat (6) @(negedge clk);
      check(wr_n - base == int'(VEC[k].grant), "R7 R8 R9 forwarded count",
            32'(wr_n - base), 32'(VEC[k].grant));
      for (int i = 0; i < int'(VEC[k].grant); i++)
        check(base + i < 64 && log_data[base+i] == dword(k, i) &&
              log_sel[base+i] == VEC[k].fifo && log_tag[base+i] == VEC[k].ctrl[27:24],
              "R7 forwarded word", log_data[base+i], dword(k, i));
      check(!req_valid, "R8 R9 back to idle", {31'd0, req_valid}, 32'd0);
    end

    // R11: a word sent while the decision is pending is discarded
    base = wr_n;
    send_word(32'h5302_4000);
    wait_req(seen);
    send_word(32'h9999_9999);
    check(req_valid && {req_src, req_tgt, req_count, req_index} == 20'h53024,
          "R11 pending header unchanged", {12'd0, req_src, req_tgt, req_count, req_index},
          32'h53024);
    check(wr_n == base, "R11 no write while pending", 32'(wr_n - base), 32'd0);
    decide(1'b0, 8'd9, 2'd2);
    get_reply(rep, seen);
    check(seen && rep == 32'h5302_4001, "R11 reply after pending", rep, 32'h5302_4001);
    send_word(32'h0000_00A1);
    send_word(32'h0000_00A2);
    repeat (6) @(negedge clk);
    check(wr_n - base == 2 && log_data[base] == 32'h0000_00A1 &&
          log_data[base+1] == 32'h0000_00A2, "R11 only payload forwarded",
          log_data[base], 32'h0000_00A1);

    // R8: surplus word after an OK block is decoded as a header, not written
    base = wr_n;
    send_word(32'h7C11_2345);
    wait_req(seen);
    check(seen && {req_src, req_tgt, req_count, req_index} == 20'h7C112,
          "R8 surplus word is header", {12'd0, req_src, req_tgt, req_count, req_index},
          32'h7C112);
    check(wr_n == base, "R8 surplus not written", 32'(wr_n - base), 32'd0);
    decide(1'b1, 8'd0, 2'd0);
    get_reply(rep, seen);
    check(seen && rep == 32'h7C00_2002, "R6 wait reply", rep, 32'h7C00_2002);

    // R4: rsp_valid while idle does nothing
    base = wr_n;
    decide(1'b0, 8'd5, 2'd1);
    repeat (3 * DIV) @(negedge clk);
    check(!req_valid && !tx_fs && wr_n == base, "R4 stray decision ignored",
          {30'd0, req_valid, tx_fs}, 32'd0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule